// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This engine turns a virtual page number into a physical page number by searching a hashed page table held in physical memory. A request carries the page number. The engine hashes it to a slot, which is a group of eight consecutive table words starting at the table base. It reads those words one at a time and compares the stored page number in each with the request. When all eight entries of that slot fail, it builds a second slot index and searches that slot the same way.

The result is one response. A hit carries the translated page number. A miss hands the request to software, which looks the page up in a complete backup table. Every response also reports how many table words were read.

Requests, responses and memory traffic all use valid/ready handshakes. The engine takes a new request only when it is idle. It keeps a response steady while `rsp_ready` is low. It keeps a memory read request and its address steady while `mem_req_ready` is low. It has at most one memory read in flight. It accepts the read data whenever `mem_rsp_ready` is high, and the memory may take any number of cycles to answer.

Top module: `hpt_search_engine`

## Requirements
- R1: The first slot index is `vpn[7:0] ^ vpn[15:8]`. Every word address equals `table_base + slot*8 + entry`, counted in table words. The first read goes to entry 0 of the first slot.
- R2: Inside a slot, the entries are read in the order 0, 1, … 7.
- R3: When all eight entries of the first slot fail, the second slot is the bitwise complement of the first slot index. It is read from entry 0 to entry 7.
- R4: Each table word is laid out as bit 40 valid, bits 39:20 stored page number, and bits 19:0 physical page number. An entry matches only when its valid bit is 1 and all 20 bits of its stored page number equal the request.
- R5: On the first match the engine answers `rsp_hit=1` with that entry's physical page number. It reads no further table words for that request.
- R6: When neither slot holds a match, the engine answers `rsp_hit=0` with `rsp_probes=16`.
- R7: `rsp_probes` equals the number of table words read for the request, a value from 1 to 16.
- R8: Each accepted request yields exactly one response. `req_ready` is high only while no request is in progress. The response fields stay stable until `rsp_ready` is seen high.
- R9: While `mem_req_ready` is low, a read request keeps its valid and address stable. No new read is issued while a read is still waiting for its data. Any memory latency gives the same result.
- R10: `table_base` is sampled when a request is accepted. Changing it later has no effect on that search.
- R11: After reset, `req_ready=1`, `rsp_valid=0` and `mem_req_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_base | input | 32 | Word address of slot 0, entry 0 |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_vpn | input | 20 | Page number to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 = translation found |
| rsp_ppn | output | 20 | Physical page number on a hit |
| rsp_probes | output | 5 | Table words read, 1 to 16 |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waits for read data |
| mem_rsp_data | input | 41 | Table word read |

## Verification
The bench builds the engine with its defaults: 20-bit page numbers, 256 slots of eight entries, and a 32-bit word address. With these values both hash paths are reachable. So are the hit positions of first entry, last entry of the first slot, inside the second slot, and last entry of the second slot, as well as the full 16-read miss. Entries are planted so that some share a slot and their low page bits but differ in the upper bits. An invalid entry with a matching page number is also planted. The memory model stalls requests and varies the read latency, which exercises both handshakes under back-pressure.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } hpt_state_e;
endpackage

// File: rtl/hpt_hash.sv
// Forms the word address of one table entry from the page number,
// the slot choice (primary or complement) and the entry index.
module hpt_hash #(
  parameter int VPN_W  = 20,
  parameter int SLOT_W = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic              use_alt,
  input  logic [IDX_W-1:0]  entry,
  input  logic [ADDR_W-1:0] base,
  output logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFS_W = SLOT_W + IDX_W;

  logic [SLOT_W-1:0] prim;

  generate
    if (VPN_W >= 2*SLOT_W) begin : g_fold
      assign prim = vpn[SLOT_W-1:0] ^ vpn[2*SLOT_W-1:SLOT_W];
    end else begin : g_low
      assign prim = vpn[SLOT_W-1:0];
    end
  endgenerate

  always_comb begin
    slot = use_alt ? ~prim : prim;
    addr = base + ADDR_W'({slot, entry});
  end

  // the word offset must fit the address
  initial assert (OFS_W <= ADDR_W);
endmodule

// File: rtl/hpt_match.sv
// Decodes one table word and compares it with the requested page number.
module hpt_match #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int PTE_W = 1 + VPN_W + PPN_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [VPN_W-1:0] vpn,
  output logic             match,
  output logic [PPN_W-1:0] ppn
);
  logic             ent_valid;
  logic [VPN_W-1:0] ent_vpn;

  always_comb begin
    ent_valid = pte[PTE_W-1];
    ent_vpn   = pte[PPN_W +: VPN_W];
    ppn       = pte[PPN_W-1:0];
    match     = ent_valid && (ent_vpn == vpn);
  end
endmodule

// File: rtl/hpt_search_engine.sv
module hpt_search_engine
  import hpt_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int SLOTS  = 256,
  parameter int WAYS   = 8,
  parameter int ADDR_W = 32,
  localparam int PTE_W   = 1 + VPN_W + PPN_W,
  localparam int PROBE_W = $clog2(2*WAYS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  table_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PROBE_W-1:0] rsp_probes,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [PTE_W-1:0]   mem_rsp_data
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(WAYS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WAYS - 1);
  localparam logic [PROBE_W-1:0] MAX_PROBES = PROBE_W'(2*WAYS);

  hpt_state_e         state_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [ADDR_W-1:0]  base_q;
  logic               alt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PROBE_W-1:0] probes_q;
  logic               hit_q;
  logic [PPN_W-1:0]   ppn_q;

  logic [SLOT_W-1:0]  cur_slot;
  logic [ADDR_W-1:0]  cur_addr;
  logic               ent_match;
  logic [PPN_W-1:0]   ent_ppn;

  hpt_hash #(
    .VPN_W (VPN_W),
    .SLOT_W(SLOT_W),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W)
  ) i_hash (
    .vpn    (vpn_q),
    .use_alt(alt_q),
    .entry  (idx_q),
    .base   (base_q),
    .slot   (cur_slot),
    .addr   (cur_addr)
  );

  hpt_match #(
    .VPN_W(VPN_W),
    .PPN_W(PPN_W)
  ) i_match (
    .pte  (mem_rsp_data),
    .vpn  (vpn_q),
    .match(ent_match),
    .ppn  (ent_ppn)
  );

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_ISSUE);
    mem_rsp_ready = (state_q == ST_WAIT);
    rsp_valid     = (state_q == ST_DONE);
    mem_req_addr  = cur_addr;
    rsp_hit       = hit_q;
    rsp_ppn       = ppn_q;
    rsp_probes    = probes_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vpn_q    <= '0;
      base_q   <= '0;
      alt_q    <= 1'b0;
      idx_q    <= '0;
      probes_q <= '0;
      hit_q    <= 1'b0;
      ppn_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q    <= req_vpn;
            base_q   <= table_base;
            alt_q    <= 1'b0;
            idx_q    <= '0;
            probes_q <= '0;
            hit_q    <= 1'b0;
            ppn_q    <= '0;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            probes_q <= probes_q + 1'b1;
            if (ent_match) begin
              hit_q   <= 1'b1;
              ppn_q   <= ent_ppn;
              state_q <= ST_DONE;
            end else if (idx_q == LAST_IDX) begin
              if (!alt_q) begin
                alt_q   <= 1'b1;
                idx_q   <= '0;
                state_q <= ST_ISSUE;
              end else begin
                state_q <= ST_DONE;
              end
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_hit, rsp_ppn, rsp_probes}));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R7
  probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes >= 1) && (rsp_probes <= MAX_PROBES));

  // R6
  miss_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_probes == MAX_PROBES);

  // R3
  alt_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alt_q) |-> $past(idx_q) == LAST_IDX);
endmodule

// File: tb/test_hpt_search_engine.sv
module test_hpt_search_engine;
  localparam int NV = 7;
  localparam logic [31:0] BASE = 32'h0000_1000;

  localparam logic [19:0] V_VPN [NV] = '{20'h00312, 20'hF0312, 20'h00512,
                                         20'h00734, 20'h00956, 20'h00A00, 20'h00B01};
  localparam logic        V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [19:0] V_PPN [NV] = '{20'hAAAAA, 20'h55555, 20'h12345,
                                         20'h0C0DE, 20'h00000, 20'h0BEEF, 20'h77777};
  localparam int          V_PRB [NV] = '{1, 2, 8, 11, 16, 2, 16};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] table_base = BASE;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_hit;
  logic [19:0] rsp_ppn;
  logic [4:0]  rsp_probes;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [40:0] mem_rsp_data = '0;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  logic [40:0] mem [2048];
  logic [19:0] cur_vpn = '0;
  int          probe_n = 0;
  logic        searching = 1'b0;
  int          filler = 0;

  always #10 clk = ~clk;

  hpt_search_engine i_hpt_search_engine (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_ppn(rsp_ppn), .rsp_probes(rsp_probes),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(input string req, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] slot, input int ent, input logic v,
                     input logic [19:0] vpn, input logic [19:0] ppn);
    mem[{slot, 3'(ent)}] = {v, vpn, ppn};
  endtask

  task automatic fill(input logic [7:0] slot, input int lo, input int hi);
    for (int e = lo; e <= hi; e++) begin
      put(slot, e, 1'b1, 20'h80000 + 20'(filler), 20'h0);
      filler++;
    end
  endtask

  // memory model: stalls requests, varies latency, checks probe addresses
  initial begin
    logic        req_hs = 1'b0;
    logic        rsp_hs = 1'b0;
    logic [31:0] hs_addr = '0;
    logic        pending = 1'b0;
    logic [10:0] pend_idx = '0;
    int          lat = 0;
    int          cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (req_hs) begin
        logic [7:0]  h;
        logic [31:0] exp_a;
        h = cur_vpn[7:0] ^ cur_vpn[15:8];
        if (probe_n >= 8) h = ~h;
        exp_a = BASE + {21'b0, h, 3'(probe_n % 8)};
        if (searching)
          check("R1/R2/R3 probe address", hs_addr == exp_a, hs_addr, exp_a);
        pending = 1'b1;
        pend_idx = hs_addr[10:0];
        lat = (probe_n * 5 + 1) % 4;
        probe_n++;
      end
      if (rsp_hs) begin
        mem_rsp_valid = 1'b0;
        pending = 1'b0;
      end
      if (pending && !mem_rsp_valid) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem[pend_idx];
        end else lat--;
      end
      mem_req_ready = !pending && ((cyc % 3) != 0);
      req_hs = mem_req_valid && mem_req_ready;
      hs_addr = mem_req_addr;
      rsp_hs = mem_rsp_valid && mem_rsp_ready;
    end
  end

  task automatic lookup(input logic [19:0] vpn, input int hold, input logic scramble,
                        output logic hit, output logic [19:0] ppn, output int prb,
                        output int reads, output logic stable_ok, output logic after_ok);
    cur_vpn = vpn;
    probe_n = 0;
    searching = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn = vpn;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) table_base = 32'hDEAD_0000;
    while (!rsp_valid) @(negedge clk);
    hit = rsp_hit;
    ppn = rsp_ppn;
    prb = int'(rsp_probes);
    stable_ok = 1'b1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_hit != hit || rsp_ppn != ppn || int'(rsp_probes) != prb)
        stable_ok = 1'b0;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    after_ok = !rsp_valid && req_ready;
    reads = probe_n;
    table_base = BASE;
    searching = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic        hit;
    logic [19:0] ppn;
    int          prb;
    int          reads;
    logic        st_ok;
    logic        af_ok;

    for (int i = 0; i < 2048; i++) mem[i] = '0;
    // vec0/vec1: same slot 0x11, same low bits, different upper bits
    put(8'h11, 0, 1'b1, 20'h00312, 20'hAAAAA);
    put(8'h11, 1, 1'b1, 20'hF0312, 20'h55555);
    // vec2: last entry of primary slot 0x17
    fill(8'h17, 0, 6);
    put(8'h17, 7, 1'b1, 20'h00512, 20'h12345);
    // vec3: primary 0x33 full, alternate 0xCC entry 2
    fill(8'h33, 0, 7);
    fill(8'hCC, 0, 1);
    put(8'hCC, 2, 1'b1, 20'h00734, 20'h0C0DE);
    // vec4: both 0x5F and 0xA0 full of others
    fill(8'h5F, 0, 7);
    fill(8'hA0, 0, 7);
    // vec5: invalid matching entry before the valid one in slot 0x0A
    put(8'h0A, 0, 1'b0, 20'h00A00, 20'hBAD00);
    put(8'h0A, 1, 1'b1, 20'h00A00, 20'h0BEEF);
    // vec6: slot 0x0A full, alternate 0xF5 last entry
    fill(8'h0A, 2, 7);
    fill(8'hF5, 0, 6);
    put(8'hF5, 7, 1'b1, 20'h00B01, 20'h77777);

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 req_ready in reset", req_ready == 1'b1, 32'(req_ready), 32'd1);
    check("R11 rsp_valid in reset", rsp_valid == 1'b0, 32'(rsp_valid), 32'd0);
    check("R11 mem_req_valid in reset", mem_req_valid == 1'b0, 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 req_ready after reset", req_ready == 1'b1, 32'(req_ready), 32'd1);
    check("R11 rsp_valid after reset", rsp_valid == 1'b0, 32'(rsp_valid), 32'd0);

    for (int v = 0; v < NV; v++) begin
      lookup(V_VPN[v], 0, 1'b0, hit, ppn, prb, reads, st_ok, af_ok);
      check(V_HIT[v] ? "R5 hit flag" : "R6 miss flag", hit == V_HIT[v],
            32'(hit), 32'(V_HIT[v]));
      if (V_HIT[v]) check("R4 R5 ppn", ppn == V_PPN[v], 32'(ppn), 32'(V_PPN[v]));
      check("R7 probe count", prb == V_PRB[v], 32'(prb), 32'(V_PRB[v]));
      check("R5 R6 words read", reads == V_PRB[v], 32'(reads), 32'(V_PRB[v]));
      check("R8 single response", af_ok, 32'(af_ok), 32'd1);
    end

    // R8 R10: held response under back-pressure, base changed mid-search
    lookup(20'h00734, 6, 1'b1, hit, ppn, prb, reads, st_ok, af_ok);
    check("R8 response stable while stalled", st_ok, 32'(st_ok), 32'd1);
    check("R10 base latched hit", hit == 1'b1, 32'(hit), 32'd1);
    check("R10 base latched ppn", ppn == 20'h0C0DE, 32'(ppn), 32'h0C0DE);
    check("R8 single response after hold", af_ok, 32'(af_ok), 32'd1);

    // R9: same lookup again, different latency pattern, same result
    lookup(20'h00B01, 2, 1'b0, hit, ppn, prb, reads, st_ok, af_ok);
    check("R9 latency independent ppn", ppn == 20'h77777, 32'(ppn), 32'h77777);
    check("R9 latency independent probes", prb == 16, 32'(prb), 32'd16);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule